// File: doc/BRIEF.md
# Deep-Sleep Supply Hold-Off Timer

This block keeps the core supply switched off for a guaranteed minimum interval each time the chip enters deep sleep. A deep-sleep request drops the supply-enable output. The block then loads a down counter from a programmed count and decrements it once per prescaled tick. The tick period is a power of two, chosen by an exponent-coded prescaler field. Any wakeup request that arrives during this interval is remembered but not acted on. Once the counter is exhausted, the supply enable returns high and a one-clock grant pulse marks the wakeup.

When the deep-sleep-mode enable is low, the count has no effect. A sleep request still removes the supply, but a wakeup is honoured on the next clock. The count and prescaler code are captured at the moment of entry, so every entry gets the full programmed interval. Register writes made while the supply is off do not shorten or stretch the interval already in progress.

Top module: `pwr_hold_timer`

## Requirements
- R1: After reset, `supply_en` is 1, `wake_grant` is 0, and the block is in the supplied state.
- R2: The prescaler code n (5 bits) divides the clock by 2^(n-1) for n from 1 to 31, so code 1 gives 1, code 5 gives 16 and code 8 gives 128. Code 0 is reserved and behaves as divide-by-1.
- R3: If `sleep_req` is 1 at a clock edge while `supply_en` is 1 and `dsm_en` is 1, then `supply_en` is 0 after that edge and the down counter holds the `hold_count` value sampled at that edge.
- R4: With a wakeup requested throughout, `supply_en` stays 0 for exactly N*D+1 clock cycles after the entry edge, where N is the captured count and D is the captured divide ratio. Before the counter reaches zero, `wake_req` never raises `supply_en`.
- R5: A `wake_req` that is high for even one clock during the hold interval is latched. It is honoured when the counter expires, even if it has since dropped.
- R6: After expiry with no wakeup latched, `supply_en` stays 0 until `wake_req` is sampled high. It rises at that same edge.
- R7: `wake_grant` is a single-cycle pulse that is 1 exactly in the cycle in which `supply_en` has just risen. A `wake_req` while the supply is on produces no pulse.
- R8: If `dsm_en` is 0 at the entry edge, the count is not applied. `supply_en` goes 0, and a held `wake_req` brings it back after exactly one cycle.
- R9: Count and prescaler code are reloaded at every entry. Changes to `hold_count`, `presc_code` or `dsm_en` after the entry edge do not alter the interval in progress.
- R10: A `sleep_req` while the supply is already off is ignored and does not restart the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Request to enter deep sleep (sampled while supplied) |
| dsm_en | input | 1 | Deep-sleep-mode enable; 0 bypasses the minimum off-time |
| wake_req | input | 1 | Wakeup request |
| presc_code | input | 5 | Prescaler exponent code (divide by 2^(code-1), code 0 as 1) |
| hold_count | input | 8 | Number of prescaled ticks the supply must stay off |
| supply_en | output | 1 | Core supply enable, 1 = supplied |
| wake_grant | output | 1 | One-cycle pulse when the supply is re-enabled |

## Verification
On every cycle, the assertions check four things. The entry edge loads the counter and drops the supply. The supply cannot return while the counter is non-zero, and the counter never counts upward during a hold. Each grant pulse coincides with a supply rise. A wakeup in the expired state, or with the mode bypassed, restores the supply on the next edge. Other properties are visible only through the bench's scenarios: the exact length of the off interval for a given code and count, the latching of a short early wakeup, and the immunity of a running interval to register changes and repeated sleep requests. For these, the bench measures off-times against a computed N*D+1.

// File: rtl/pwr_hold_pkg.sv
package pwr_hold_pkg;

    typedef enum logic [1:0] {
        ST_ON    = 2'd0,
        ST_HOLD  = 2'd1,
        ST_READY = 2'd2
    } hold_state_e;

    // Exponent of the divide ratio; reserved code 0 behaves as code 1.
    function automatic int unsigned code_to_exp(input int unsigned code);
        return (code == 0) ? 0 : code - 1;
    endfunction

endpackage

// File: rtl/hold_prescaler.sv
module hold_prescaler #(
    parameter int CODE_W = 5,
    parameter int PRE_W  = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              run,
    input  logic [CODE_W-1:0] exp_i,
    output logic              tick
);
    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] limit;

    always_comb begin
        if (int'(exp_i) >= PRE_W) limit = '1;
        else                      limit = {PRE_W{1'b1}} >> (PRE_W - int'(exp_i));
    end

    assign tick = run && (pcnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clear)  pcnt <= '0;
        else if (run)      pcnt <= tick ? '0 : pcnt + 1'b1;
    end
endmodule

// File: rtl/hold_downcounter.sv
module hold_downcounter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);
    assign zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (dec && !zero) cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/hold_ctrl_fsm.sv
module hold_ctrl_fsm
    import pwr_hold_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sleep_req,
    input  logic        dsm_en,
    input  logic        wake_req,
    input  logic        cnt_zero,
    output hold_state_e state,
    output logic        enter,
    output logic        run,
    output logic        supply_en,
    output logic        wake_grant
);
    hold_state_e nxt;
    logic        wake_pend;
    logic        want_wake;

    assign want_wake = wake_pend || wake_req;

    always_comb begin
        nxt   = state;
        enter = 1'b0;
        unique case (state)
            ST_ON: begin
                if (sleep_req) begin
                    enter = 1'b1;
                    nxt   = dsm_en ? ST_HOLD : ST_READY;
                end
            end
            ST_HOLD: begin
                if (cnt_zero) nxt = want_wake ? ST_ON : ST_READY;
            end
            ST_READY: begin
                if (want_wake) nxt = ST_ON;
            end
            default: nxt = ST_ON;
        endcase
    end

    assign run       = (state == ST_HOLD) && !cnt_zero;
    assign supply_en = (state == ST_ON);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_ON;
            wake_pend  <= 1'b0;
            wake_grant <= 1'b0;
        end else begin
            state      <= nxt;
            wake_grant <= (nxt == ST_ON) && (state != ST_ON);
            if (enter || nxt == ST_ON)           wake_pend <= 1'b0;
            else if (state == ST_HOLD && wake_req) wake_pend <= 1'b1;
        end
    end
endmodule

// File: rtl/pwr_hold_timer.sv
module pwr_hold_timer
    import pwr_hold_pkg::*;
#(
    parameter int CODE_W = 5,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_req,
    input  logic              dsm_en,
    input  logic              wake_req,
    input  logic [CODE_W-1:0] presc_code,
    input  logic [CNT_W-1:0]  hold_count,
    output logic              supply_en,
    output logic              wake_grant
);
    localparam int PRE_W = (1 << CODE_W) - 2;

    hold_state_e       state;
    logic              enter;
    logic              run;
    logic              tick;
    logic              cnt_zero;
    logic [CNT_W-1:0]  cnt_q;
    logic [CODE_W-1:0] exp_q;
    logic              in_hold;

    assign in_hold = (state == ST_HOLD);

    // Exponent captured at entry so later writes leave the running interval alone.
    always_ff @(posedge clk) begin
        if (rst)        exp_q <= CODE_W'(code_to_exp(8));
        else if (enter) exp_q <= CODE_W'(code_to_exp(int'(presc_code)));
    end

    hold_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sleep_req  (sleep_req),
        .dsm_en     (dsm_en),
        .wake_req   (wake_req),
        .cnt_zero   (cnt_zero),
        .state      (state),
        .enter      (enter),
        .run        (run),
        .supply_en  (supply_en),
        .wake_grant (wake_grant)
    );

    hold_prescaler #(.CODE_W(CODE_W), .PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .clear (enter),
        .run   (run),
        .exp_i (exp_q),
        .tick  (tick)
    );

    hold_downcounter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (enter),
        .load_val (dsm_en ? hold_count : '0),
        .dec      (tick),
        .cnt      (cnt_q),
        .zero     (cnt_zero)
    );
endmodule

// File: rtl/hold_timer_checker.sv
module hold_timer_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             sleep_req,
    input logic             dsm_en,
    input logic             wake_req,
    input logic [CNT_W-1:0] hold_count,
    input logic             supply_en,
    input logic             wake_grant,
    input logic             in_hold,
    input logic             cnt_zero,
    input logic [CNT_W-1:0] cnt_q
);
    assert_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (supply_en && sleep_req && dsm_en) |=> (!supply_en && in_hold && cnt_q == $past(hold_count)))
        else $error("entry did not load counter");

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (in_hold && !cnt_zero) |=> !supply_en)
        else $error("supply returned before expiry");

    assert_no_count_up_R4: assert property (@(posedge clk) disable iff (rst)
        (in_hold && $past(in_hold)) |-> (cnt_q <= $past(cnt_q)))
        else $error("counter rose during hold");

    assert_grant_on_rise_R7: assert property (@(posedge clk) disable iff (rst)
        wake_grant |-> (supply_en && !$past(supply_en)))
        else $error("grant without supply rise");

    assert_rise_has_grant_R7: assert property (@(posedge clk) disable iff (rst)
        (supply_en && !$past(supply_en)) |-> wake_grant)
        else $error("supply rise without grant");

    assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
        (supply_en && sleep_req && !dsm_en) |=> (!supply_en && !in_hold))
        else $error("bypass entry entered hold");

    assert_ready_wake_R6: assert property (@(posedge clk) disable iff (rst)
        (!supply_en && !in_hold && wake_req) |=> supply_en)
        else $error("wake in expired state not honoured");
endmodule

bind pwr_hold_timer hold_timer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sleep_req  (sleep_req),
    .dsm_en     (dsm_en),
    .wake_req   (wake_req),
    .hold_count (hold_count),
    .supply_en  (supply_en),
    .wake_grant (wake_grant),
    .in_hold    (in_hold),
    .cnt_zero   (cnt_zero),
    .cnt_q      (cnt_q)
);

// File: tb/test_pwr_hold_timer.sv
module test_pwr_hold_timer;
    logic       clk = 1'b0;
    logic       rst;
    logic       sleep_req, dsm_en, wake_req;
    logic [4:0] presc_code;
    logic [7:0] hold_count;
    logic       supply_en, wake_grant;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    pwr_hold_timer i_pwr_hold_timer (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .dsm_en(dsm_en),
        .wake_req(wake_req), .presc_code(presc_code), .hold_count(hold_count),
        .supply_en(supply_en), .wake_grant(wake_grant)
    );

    function automatic int divide_of(input int code);
        return (code == 0) ? 1 : (1 << (code - 1));
    endfunction

    function automatic int expect_low(input int n, input int code, input bit dsm);
        return dsm ? n * divide_of(code) + 1 : 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // mode 0: wake held from entry; 1: one-cycle wake early in hold; 2: wake only after expiry
    task automatic run_entry(input int n, input int code, input bit dsm, input int mode,
                             input bit perturb, input string req);
        int exp_cycles = expect_low(n, code, dsm);
        int low = 0;
        @(negedge clk);
        hold_count = 8'(n); presc_code = 5'(code); dsm_en = dsm;
        sleep_req = 1'b1; wake_req = (mode == 0);
        @(negedge clk);
        sleep_req = 1'b0;
        if (mode == 2) begin
            for (int i = 0; i < exp_cycles + 3; i++) begin
                if (supply_en) low = -1000;
                @(negedge clk);
            end
            check(!supply_en, "R6", supply_en, 0);
            wake_req = 1'b1;
            @(negedge clk);
            wake_req = 1'b0;
            check(supply_en && wake_grant, "R6", {supply_en, wake_grant}, 3);
            check(low == 0, "R4", low, 0);
        end else begin
            while (!supply_en && low < 100000) begin
                low++;
                if (wake_grant) check(0, "R7", 1, 0);
                if (low == 1) begin
                    if (mode == 1) wake_req = 1'b1;
                    if (perturb) begin
                        hold_count = 8'($urandom_range(0, 255));
                        presc_code = 5'($urandom_range(0, 31));
                        dsm_en = ~dsm_en;
                    end
                end
                if (low == 2 && mode == 1) wake_req = 1'b0;
                if (perturb && exp_cycles > 6 && low == 2) sleep_req = 1'b1;
                if (low == 3) sleep_req = 1'b0;
                @(negedge clk);
            end
            wake_req = 1'b0;
            check(low == exp_cycles, req, low, exp_cycles);
            check(wake_grant == 1'b1, "R7", wake_grant, 1);
        end
        @(negedge clk);
        check(supply_en && !wake_grant, "R7", {supply_en, wake_grant}, 2);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; sleep_req = 0; dsm_en = 1; wake_req = 0;
        presc_code = 5'd8; hold_count = 8'd0;
        repeat (3) @(negedge clk);
        check(supply_en && !wake_grant, "R1", {supply_en, wake_grant}, 2);
        rst = 1'b0;
        @(negedge clk);
        check(supply_en && !wake_grant, "R1", {supply_en, wake_grant}, 2);

        // R7: wake while supplied gives no pulse
        wake_req = 1'b1;
        repeat (2) @(negedge clk);
        check(supply_en && !wake_grant, "R7", {supply_en, wake_grant}, 2);
        wake_req = 1'b0;

        // directed corners
        run_entry(3, 1, 1, 0, 0, "R3");   // divide by 1
        run_entry(4, 0, 1, 0, 0, "R2");   // reserved code acts as 1
        run_entry(2, 8, 1, 0, 0, "R2");   // divide by 128
        run_entry(0, 5, 1, 0, 0, "R4");   // zero count
        run_entry(5, 3, 1, 1, 0, "R5");   // short early wake latched
        run_entry(4, 2, 1, 2, 0, "R6");   // wake only after expiry
        run_entry(200, 1, 0, 0, 0, "R8"); // bypass ignores count
        run_entry(9, 2, 1, 0, 1, "R9");   // register changes mid-hold
        run_entry(12, 1, 1, 0, 1, "R10"); // repeated sleep request while off

        for (int k = 0; k < 40; k++) begin
            int n    = $urandom_range(0, 20);
            int code = $urandom_range(0, 5);
            bit dsm  = ($urandom_range(0, 3) != 0);
            int mode = $urandom_range(0, 2);
            bit pert = $urandom_range(0, 1);
            run_entry(n, code, dsm, mode, pert, "R4");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule